// File: doc/BRIEF.md
# Dynamic Event Packer into Link Frames

This block takes zero-suppressed events from the front-end side and packs them back to back into fixed-width link frames. Every event is written into a small derandomizer buffer together with its crossing identifier, its hit count and its channel data. The packer turns each event into a bit record: a header followed by the data of the hit channels. It appends the record to a residue register of pending bits. A frame leaves the block on any clock in which at least one full frame width of bits is pending. An event can therefore begin part-way through a frame and run on into the following frames, with no padding between events.

The frame width is a build-time parameter (80 or 112 bits), as are the channel count, the channel width, the crossing-identifier width and the buffer depth. The header layout is chosen per event by a mode input. It is either a fixed-length header, or a variable-length header that drops the length field for empty crossings. The hit count is an 8-bit number of channels, not a bit count. The source is held off through a ready signal while the buffer is full, so no event is ever lost.

Top module: `evt_frame_packer`

## Requirements
- R1: After reset, `frame_valid` is 0, `buf_empty` is 1, `buf_full` is 0 and `in_ready` is 1.
- R2: Fixed header mode (`in_hdr_var`=0). The record starts with the crossing identifier in bits [BXID_W-1:0], followed by the 8-bit hit count in bits [BXID_W+7:BXID_W].
- R3: Variable header mode (`in_hdr_var`=1). Record bit 0 is a flag equal to (hit count != 0), and the identifier follows in bits [BXID_W:1]. Only when the flag is 1 is the 8-bit hit count added in bits [BXID_W+8:BXID_W+1].
- R4: The header is followed by exactly count*CH_W data bits, with channel i at offset i*CH_W. Channel data at index count and above has no effect on the output stream.
- R5: The stream runs LSB first: frame bit 0 is the oldest pending bit. Records follow each other with no gap or padding across frame boundaries. `frame_valid` is 1 exactly when at least FRAME_W bits are pending, and a partial frame is held back.
- R6: With the buffer and the residue both empty, an event accepted at edge k enters the residue at edge k+1. If its record is at least FRAME_W bits long, `frame_valid` is 1 in the cycle after edge k+1 and not before.
- R7: A crossing with a hit count of 0 still produces its header in the stream.
- R8: `buf_full` is 1 when DEPTH events are buffered. `in_ready` is then 0, and every accepted event later appears in the stream.
- R9: `buf_empty` is 1 exactly when no accepted event is waiting to be moved into the residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Event offered |
| in_ready | output | 1 | Event accepted on this edge when valid |
| in_bxid | input | BXID_W | Crossing identifier |
| in_len | input | 8 | Number of hit channels |
| in_data | input | N_CH*CH_W | Compacted channel data, channel 0 lowest |
| in_hdr_var | input | 1 | 1 selects the variable-length header |
| frame_valid | output | 1 | A frame is on `frame_data` this cycle |
| frame_data | output | FRAME_W | Link frame, bit 0 sent first |
| buf_full | output | 1 | Buffer holds DEPTH events |
| buf_empty | output | 1 | Buffer holds no event |

## Verification
The bench drives each event just after a falling edge, so it is written at the next rising edge (k). At the earliest it moves into the residue at edge k+1, and its first frame is valid from just after k+1. The latency scenario therefore samples `frame_valid` and `buf_empty` on the falling edges after k, k+1 and k+2, expecting 0/0, 1/1 and then 0 with 68 bits held back. Every other frame is checked on the falling edge on which `frame_valid` is high, against a bit queue that the bench fills from the header and data rules. Each scenario then lets the block go idle and checks the frame count and the leftover bit count, which must equal the number of bits sent modulo FRAME_W.

// File: rtl/evt_frame_packer.sv
module evt_frame_packer #(
  parameter int FRAME_W = 80,
  parameter int N_CH    = 32,
  parameter int CH_W    = 4,
  parameter int BXID_W  = 12,
  parameter int DEPTH   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [BXID_W-1:0]      in_bxid,
  input  logic [7:0]             in_len,
  input  logic [N_CH*CH_W-1:0]   in_data,
  input  logic                   in_hdr_var,
  output logic                   frame_valid,
  output logic [FRAME_W-1:0]     frame_data,
  output logic                   buf_full,
  output logic                   buf_empty
);
  localparam int LEN_W   = 8;
  localparam int DAT_W   = N_CH * CH_W;
  localparam int HDR_MAX = BXID_W + LEN_W + 1;
  localparam int REC_W   = HDR_MAX + DAT_W;
  localparam int RES_W   = FRAME_W - 1 + REC_W;
  localparam int FILL_W  = $clog2(RES_W + 1);
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int ENT_W   = 1 + LEN_W + BXID_W + DAT_W;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  logic [ENT_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              push, pop;

  assign buf_full  = (cnt == CNT_W'(DEPTH));
  assign buf_empty = (cnt == '0);
  assign in_ready  = !buf_full;
  assign push      = in_valid && in_ready;

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= {in_hdr_var, in_len, in_bxid, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  logic              h_var;
  logic [LEN_W-1:0]  h_len;
  logic [BXID_W-1:0] h_bxid;
  logic [DAT_W-1:0]  h_data, dmask;
  logic [HDR_MAX-1:0] hdr;
  logic [FILL_W-1:0] hdr_n, rec_n;
  logic [REC_W-1:0]  rec;

  assign {h_var, h_len, h_bxid, h_data} = mem[rd_ptr];

  always_comb begin
    hdr = '0;
    if (!h_var) begin
      hdr[BXID_W-1:0]     = h_bxid;
      hdr[BXID_W +: LEN_W] = h_len;
      hdr_n = FILL_W'(BXID_W + LEN_W);
    end else if (h_len == '0) begin
      hdr[BXID_W:1] = h_bxid;
      hdr_n = FILL_W'(BXID_W + 1);
    end else begin
      hdr[0]                   = 1'b1;
      hdr[BXID_W:1]            = h_bxid;
      hdr[BXID_W+1 +: LEN_W]   = h_len;
      hdr_n = FILL_W'(HDR_MAX);
    end
  end

  always_comb begin
    dmask = '0;
    for (int i = 0; i < N_CH; i++)
      if (i < int'(h_len)) dmask[i*CH_W +: CH_W] = h_data[i*CH_W +: CH_W];
  end

  assign rec   = {{DAT_W{1'b0}}, hdr} | ({{HDR_MAX{1'b0}}, dmask} << hdr_n);
  assign rec_n = hdr_n + FILL_W'(h_len) * FILL_W'(CH_W);

  logic [RES_W-1:0]  res;
  logic [FILL_W-1:0] fill, base;
  logic              emit;

  assign emit = (fill >= FILL_W'(FRAME_W));
  assign base = emit ? fill - FILL_W'(FRAME_W) : fill;
  assign pop  = !buf_empty && (base < FILL_W'(FRAME_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res  <= '0;
      fill <= '0;
    end else begin
      res  <= (emit ? res >> FRAME_W : res)
            | (pop ? ({{(RES_W-REC_W){1'b0}}, rec} << base) : '0);
      fill <= base + (pop ? rec_n : '0);
    end
  end

  assign frame_valid = emit;
  assign frame_data  = res[FRAME_W-1:0];

  p_hold_partial_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> fill >= $past(fill));
  p_emit_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !pop) |=> fill == $past(fill) - FILL_W'(FRAME_W));
  p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> int'(in_len) <= N_CH);
  p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !pop) |=> buf_full);
  p_empty_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && !(in_valid && in_ready)) |=> buf_empty);
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_full && buf_empty));
endmodule

// File: tb/sim_evt_frame_packer.sv
`timescale 1ns/100ps
module sim_evt_frame_packer;
  localparam int FW = 80, NCH = 32, CW = 4, BW = 12, DEP = 8, DW = NCH*CW;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_hdr_var = 0;
  logic [BW-1:0] in_bxid = '0;
  logic [7:0]    in_len = '0;
  logic [DW-1:0] in_data = '0;
  logic frame_valid, buf_full, buf_empty;
  logic [FW-1:0] frame_data, ef;

  int n_run = 0, n_fail = 0, total_bits = 0, n_frames = 0;
  bit q[$];
  string cur = "R5";
  bit saw_full = 0, bad_ready = 0, done = 0;

  always #2.5 clk = ~clk;

  evt_frame_packer #(.FRAME_W(FW), .N_CH(NCH), .CH_W(CW), .BXID_W(BW), .DEPTH(DEP)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bxid(in_bxid), .in_len(in_len), .in_data(in_data), .in_hdr_var(in_hdr_var),
    .frame_valid(frame_valid), .frame_data(frame_data),
    .buf_full(buf_full), .buf_empty(buf_empty));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (buf_full) saw_full = 1;
    if (buf_full && in_ready) bad_ready = 1;
    if (frame_valid) begin
      if (q.size() < FW) chk(0, cur, "frame with too few pending bits", q.size(), FW);
      else begin
        for (int i = 0; i < FW; i++) ef[i] = q.pop_front();
        chk(frame_data == ef, cur, "frame content", frame_data, ef);
      end
      n_frames++;
    end
  end

  task automatic put(input bit b); q.push_back(b); total_bits++; endtask

  task automatic expect_event(input logic [BW-1:0] bx, input logic [7:0] len,
                              input logic [DW-1:0] d, input bit var_h);
    if (var_h) begin
      put(len != 0);
      for (int i = 0; i < BW; i++) put(bx[i]);
      if (len != 0) for (int i = 0; i < 8; i++) put(len[i]);
    end else begin
      for (int i = 0; i < BW; i++) put(bx[i]);
      for (int i = 0; i < 8; i++) put(len[i]);
    end
    for (int c = 0; c < int'(len); c++)
      for (int b = 0; b < CW; b++) put(d[c*CW+b]);
  endtask

  function automatic logic [DW-1:0] mkdata(input int seed);
    logic [DW-1:0] d;
    for (int c = 0; c < NCH; c++) d[c*CW +: CW] = CW'(c*5 + seed + 1);
    return d;
  endfunction

  task automatic send(input logic [BW-1:0] bx, input logic [7:0] len, input bit var_h, input int seed);
    in_valid = 1; in_bxid = bx; in_len = len; in_hdr_var = var_h; in_data = mkdata(seed);
    while (!in_ready) @(negedge clk);
    expect_event(bx, len, in_data, var_h);
    @(negedge clk);
  endtask

  task automatic idle_wait(input int n);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_quiet(input string req);
    chk(n_frames == total_bits / FW, req, "frame count", n_frames, total_bits / FW);
    chk(q.size() == total_bits % FW, req, "bits held back", q.size(), total_bits % FW);
    chk(frame_valid == 0, req, "no partial frame", frame_valid, 0);
  endtask

  task automatic t_reset;
    chk(frame_valid == 0, "R1", "frame_valid", frame_valid, 0);
    chk(buf_empty == 1, "R1", "buf_empty", buf_empty, 1);
    chk(buf_full == 0, "R1", "buf_full", buf_full, 0);
    chk(in_ready == 1, "R1", "in_ready", in_ready, 1);
  endtask

  task automatic t_latency;
    cur = "R6";
    send(12'h3A5, 8'd32, 0, 3);
    in_valid = 0;
    chk(frame_valid == 0, "R6", "valid one edge after accept", frame_valid, 0);
    chk(buf_empty == 0, "R9", "event buffered", buf_empty, 0);
    @(negedge clk);
    chk(frame_valid == 1, "R6", "valid two edges after accept", frame_valid, 1);
    chk(buf_empty == 1, "R9", "event moved out", buf_empty, 1);
    @(negedge clk);
    chk(frame_valid == 0, "R5", "68 bits held back", frame_valid, 0);
    idle_wait(4);
    check_quiet("R6");
  endtask

  task automatic t_fixed;
    cur = "R2";
    send(12'h001, 8'd3, 0, 1);
    send(12'hFFE, 8'd7, 0, 2);
    cur = "R4";
    send(12'h155, 8'd1, 0, 9);
    send(12'h2AA, 8'd32, 0, 4);
    send(12'h0F0, 8'd13, 0, 7);
    idle_wait(6);
    check_quiet("R4");
  endtask

  task automatic t_var;
    cur = "R3";
    send(12'h7C1, 8'd0, 1, 0);
    send(12'h012, 8'd5, 1, 5);
    send(12'h813, 8'd0, 1, 0);
    send(12'hABC, 8'd12, 1, 8);
    send(12'h444, 8'd2, 0, 6);
    send(12'h445, 8'd31, 1, 11);
    idle_wait(6);
    check_quiet("R3");
  endtask

  task automatic t_empty;
    cur = "R7";
    for (int i = 0; i < 8; i++) send(BW'(i + 40), 8'd0, 0, i);
    for (int i = 0; i < 6; i++) send(BW'(i + 90), 8'd0, 1, i);
    idle_wait(6);
    check_quiet("R7");
  endtask

  task automatic t_full;
    cur = "R8";
    saw_full = 0; bad_ready = 0;
    for (int i = 0; i < 40; i++) send(BW'(i * 37), 8'd32, i[0], i);
    idle_wait(120);
    chk(saw_full == 1, "R8", "buffer reached full", saw_full, 1);
    chk(bad_ready == 0, "R8", "ready low while full", bad_ready, 0);
    chk(buf_empty == 1, "R9", "drained", buf_empty, 1);
    check_quiet("R8");
  endtask

  task automatic t_nopad;
    cur = "R5";
    send(12'h321, 8'd4, 0, 2);
    idle_wait(20);
    check_quiet("R5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_latency;
    t_fixed;
    t_var;
    t_empty;
    t_full;
    t_nopad;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule